// File: doc/BRIEF.md
# Two-Channel DAC Serial Load Front End

This block is the digital front end of a two-channel digital-to-analog converter. It runs from one system clock. A host writes 16-bit frames over a three-wire link made of an active-low frame select, a serial clock and a data line. The block oversamples all three lines through synchronizers and takes a data bit on every falling edge of the serial clock. It stops after sixteen bits. A frame that is cut short by the select line returning high is thrown away.

Each complete frame is placed in the staging register of the channel it addresses. The staging registers do not drive anything. A separate active-low load line copies both staging registers into the live registers on one clock edge, so the two channels change together. Each live register presents its 12-bit code, a reference-buffer enable bit and a 2-bit power mode to the analog side. The analog side itself is outside this block.

Frame layout, first bit on the wire first: bit 15 is the channel select (0 = channel A, 1 = channel B), bit 14 is the reference-buffer enable, bits 13:12 are the power mode, and bits 11:0 are the code. The system clock must run at least four times as fast as the serial clock.

Top module: `dual_dac_serial_front`

## Requirements
- R1: While reset is asserted, and after it is released, every code, reference-buffer bit and power-mode output reads zero, and both staging registers are zero, until a load transfers new contents.
- R2: A frame is 16 bits sampled on serial-clock falling edges, most significant bit first; bit 15 selects the channel (0 = A, 1 = B), bit 14 becomes that channel's reference-buffer bit, bits 13:12 become its power mode and bits 11:0 its code.
- R3: A completed frame changes only the staging register; while load is high the live outputs keep their values.
- R4: Driving load low copies both staging registers into the live registers, and both channels' outputs change on the same system-clock cycle.
- R5: If the select line goes high before the 16th falling edge, the partial frame is discarded and no register changes.
- R6: After the 16th falling edge, further serial-clock edges are ignored until the select line goes high and then low again.
- R7: If load is already held low when a frame completes, the new word reaches the addressed channel's outputs without any further load activity.
- R8: Serial-clock edges while the select line is high shift nothing, so they do not disturb the bit count of the next frame.
- R9: A frame changes only the staging register of the channel it addresses; the other channel keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low transfer of staging to live registers |
| dac_a_code | output | 12 | Live code, channel A |
| dac_a_refbuf | output | 1 | Reference-buffer enable, channel A |
| dac_a_pdmode | output | 2 | Power mode, channel A |
| dac_b_code | output | 12 | Live code, channel B |
| dac_b_refbuf | output | 1 | Reference-buffer enable, channel B |
| dac_b_pdmode | output | 2 | Power mode, channel B |

## Verification
The hardest cases to reach from the pins are frames of the wrong length: a frame aborted part-way, and a frame followed by surplus serial-clock pulses under the same select. The bench builds frames from separate open, clock-bits and close tasks, so any bit count can be sent, and it also sends stray clocks while the select line is high. A frame that lands while load is already held low is driven on purpose to check that the word passes straight through. A cycle-accurate behavioural model compares both live registers on every clock, and the cycles on which each channel changes are recorded to confirm that they update together.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int FRAME_W = 16;
  localparam int CODE_W  = 12;
  localparam int PD_W    = 2;
  localparam int CH_W    = 1;

  typedef struct packed {
    logic              refbuf;
    logic [PD_W-1:0]   pdmode;
    logic [CODE_W-1:0] code;
  } chan_word_t;

  localparam int WORD_W = $bits(chan_word_t);

  typedef logic [FRAME_W-1:0] frame_t;

  // channel address sits in the top bits of the frame
  function automatic logic [CH_W-1:0] frame_chan(input frame_t f);
    return f[FRAME_W-1 -: CH_W];
  endfunction

  // everything below the address is the channel's control word
  function automatic chan_word_t frame_payload(input frame_t f);
    return chan_word_t'(f[WORD_W-1:0]);
  endfunction
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int            W       = 4,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dacif_frame_rx.sv
module dacif_frame_rx
  import dacif_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fs_n_s,
  input  logic   sclk_s,
  input  logic   sdi_s,
  output logic   wr_stb,
  output frame_t wr_word,
  output logic   frame_done
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic             sclk_prev;
  logic             sclk_fall;
  logic [CNT_W-1:0] bit_cnt;
  frame_t           shreg;

  assign sclk_fall = sclk_prev & ~sclk_s;
  assign wr_word   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev  <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      wr_stb     <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      wr_stb    <= 1'b0;
      if (fs_n_s) begin
        bit_cnt    <= '0;
        frame_done <= 1'b0;
      end else if (sclk_fall && !frame_done) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_s};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt    <= '0;
          frame_done <= 1'b1;
          wr_stb     <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dacif_chan_bank.sv
module dacif_chan_bank
  import dacif_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  frame_t                  wr_word,
  input  logic                    load_n_s,
  output chan_word_t [NUM_CH-1:0] in_words,
  output chan_word_t [NUM_CH-1:0] dac_words
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    assign hit = wr_stb && (frame_chan(wr_word) == CH_W'(ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   in_words[ch] <= '0;
      else if (hit) in_words[ch] <= frame_payload(wr_word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dac_words[ch] <= '0;
      else if (!load_n_s) dac_words[ch] <= in_words[ch];
    end
  end
endmodule

// File: rtl/dual_dac_serial_front.sv
module dual_dac_serial_front
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              load_n,
  output logic [CODE_W-1:0] dac_a_code,
  output logic              dac_a_refbuf,
  output logic [PD_W-1:0]   dac_a_pdmode,
  output logic [CODE_W-1:0] dac_b_code,
  output logic              dac_b_refbuf,
  output logic [PD_W-1:0]   dac_b_pdmode
);
  localparam int NUM_CH = 2;
  localparam int NPIN   = 4;
  // idle levels: load and select high, clock and data low
  localparam logic [NPIN-1:0] PIN_IDLE = 4'b1100;

  logic [NPIN-1:0] pins_raw, pins_s;
  logic            load_n_s, fs_n_s, sclk_s, sdi_s;

  // named internal events, also watched by the checker
  logic                    wr_stb;
  logic                    frame_done;
  frame_t                  wr_word;
  chan_word_t [NUM_CH-1:0] in_words;
  chan_word_t [NUM_CH-1:0] dac_words;

  assign pins_raw = {load_n, sync_n, sclk, sdin};

  dacif_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign {load_n_s, fs_n_s, sclk_s, sdi_s} = pins_s;

  dacif_frame_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_n_s     (fs_n_s),
    .sclk_s     (sclk_s),
    .sdi_s      (sdi_s),
    .wr_stb     (wr_stb),
    .wr_word    (wr_word),
    .frame_done (frame_done)
  );

  dacif_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_word   (wr_word),
    .load_n_s  (load_n_s),
    .in_words  (in_words),
    .dac_words (dac_words)
  );

  assign dac_a_code   = dac_words[0].code;
  assign dac_a_refbuf = dac_words[0].refbuf;
  assign dac_a_pdmode = dac_words[0].pdmode;
  assign dac_b_code   = dac_words[1].code;
  assign dac_b_refbuf = dac_words[1].refbuf;
  assign dac_b_pdmode = dac_words[1].pdmode;
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker
  import dacif_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fs_n_s,
  input logic                    load_n_s,
  input logic                    wr_stb,
  input logic                    frame_done,
  input chan_word_t [NUM_CH-1:0] in_words,
  input chan_word_t [NUM_CH-1:0] dac_words
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (dac_words == '0) && (in_words == '0));

  assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_n_s |=> $stable(dac_words));

  assert_stage_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(in_words));

  assert_load_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_s |=> (dac_words == $past(in_words)));

  assert_abort_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fs_n_s |=> !wr_stb);

  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !fs_n_s) |=> !wr_stb);
endmodule

bind dual_dac_serial_front dacif_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fs_n_s     (fs_n_s),
  .load_n_s   (load_n_s),
  .wr_stb     (wr_stb),
  .frame_done (frame_done),
  .in_words   (in_words),
  .dac_words  (dac_words)
);

// File: tb/dual_dac_serial_front_tb_top.sv
module dual_dac_serial_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic clk = 1'b0;
  logic rst_n, sync_n, sclk, sdin, load_n;
  logic [11:0] dac_a_code, dac_b_code;
  logic        dac_a_refbuf, dac_b_refbuf;
  logic [1:0]  dac_a_pdmode, dac_b_pdmode;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_serial_front dut_i (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .load_n(load_n),
    .dac_a_code(dac_a_code), .dac_a_refbuf(dac_a_refbuf), .dac_a_pdmode(dac_a_pdmode),
    .dac_b_code(dac_b_code), .dac_b_refbuf(dac_b_refbuf), .dac_b_pdmode(dac_b_pdmode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // pin history: index 0 = this edge's sample, higher = older
  bit  h_fs[4], h_sc[4], h_sd[4], h_ld[4];
  int  m_bits;
  bit  m_done, m_pend;
  int  m_acc, m_pword;
  logic [14:0] m_stage[2], m_live[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        h_fs[i] = 1; h_sc[i] = 0; h_sd[i] = 0; h_ld[i] = 1;
      end
      m_bits = 0; m_done = 0; m_pend = 0; m_acc = 0; m_pword = 0;
      for (int c = 0; c < 2; c++) begin m_stage[c] = '0; m_live[c] = '0; end
    end else begin
      for (int i = 3; i > 0; i--) begin
        h_fs[i] = h_fs[i-1]; h_sc[i] = h_sc[i-1];
        h_sd[i] = h_sd[i-1]; h_ld[i] = h_ld[i-1];
      end
      h_fs[0] = sync_n; h_sc[0] = sclk; h_sd[0] = sdin; h_ld[0] = load_n;
      if (!h_ld[2]) begin m_live[0] = m_stage[0]; m_live[1] = m_stage[1]; end
      if (m_pend) begin
        m_stage[(m_pword >> 15) & 1] = 15'(m_pword & 32'h7FFF);
        m_pend = 0;
      end
      if (h_fs[2]) begin
        m_bits = 0; m_done = 0;
      end else if (h_sc[3] && !h_sc[2] && !m_done) begin
        m_acc = (m_acc << 1) | int'(h_sd[2]);
        m_bits++;
        if (m_bits == 16) begin
          m_pend = 1; m_pword = m_acc & 32'hFFFF; m_done = 1; m_bits = 0;
        end
      end
    end
  end

  // per-clock comparison plus change-cycle tracking
  int cyc = 0;
  int a_cyc, b_cyc;
  logic [14:0] prev_a = '0, prev_b = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(cur_req, 32'({dac_a_refbuf, dac_a_pdmode, dac_a_code}), 32'(m_live[0]));
      chk(cur_req, 32'({dac_b_refbuf, dac_b_pdmode, dac_b_code}), 32'(m_live[1]));
    end
    if ({dac_a_refbuf, dac_a_pdmode, dac_a_code} != prev_a) a_cyc = cyc;
    if ({dac_b_refbuf, dac_b_pdmode, dac_b_code} != prev_b) b_cyc = cyc;
    prev_a = {dac_a_refbuf, dac_a_pdmode, dac_a_code};
    prev_b = {dac_b_refbuf, dac_b_pdmode, dac_b_code};
  end

  // ---------------- stimulus tasks ----------------
  task automatic frame_open();
    sync_n = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clock_bits(input logic [31:0] pat, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = pat[i]; sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
      repeat (HALF) @(negedge clk);
    end
    sclk = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_close();
    sync_n = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] w);
    frame_open();
    clock_bits(32'(w), 16);
    frame_close();
  endtask

  task automatic pulse_load();
    load_n = 0;
    repeat (4) @(negedge clk);
    load_n = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sync_n = 1; sclk = 1; sdin = 0; load_n = 1;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", 32'(dac_a_code), 0); chk("R1", 32'(dac_b_code), 0);
    chk("R1", 32'({dac_a_refbuf, dac_a_pdmode, dac_b_refbuf, dac_b_pdmode}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    pulse_load();
    chk("R1", 32'({dac_a_code, dac_b_code}), 0);

    // R2/R3: frame to A, outputs unchanged until load
    cur_req = "R3";
    send_frame(16'h6ABC);
    repeat (6) @(negedge clk);
    chk("R3", 32'(dac_a_code), 0);
    cur_req = "R2";
    pulse_load();
    chk("R2", 32'(dac_a_code), 32'hABC);
    chk("R2", 32'(dac_a_refbuf), 1);
    chk("R2", 32'(dac_a_pdmode), 2);

    // R4: both channels staged, one load updates both together
    cur_req = "R4";
    send_frame(16'h9123);
    send_frame(16'h2456);
    a_cyc = -1; b_cyc = -2;
    pulse_load();
    chk("R4", 32'(a_cyc), 32'(b_cyc));
    chk("R4", 32'(dac_a_code), 32'h456);
    chk("R4", 32'(dac_b_code), 32'h123);
    chk("R4", 32'(dac_b_pdmode), 1);

    // R5: aborted frame after 10 bits
    cur_req = "R5";
    frame_open();
    clock_bits(32'h2D5, 10);
    frame_close();
    pulse_load();
    chk("R5", 32'(dac_b_code), 32'h123);
    chk("R5", 32'(dac_a_code), 32'h456);

    // R6: surplus clocks after the 16th bit; R9: other channel untouched
    cur_req = "R6";
    frame_open();
    clock_bits(32'h9ABCF, 20);
    frame_close();
    pulse_load();
    chk("R6", 32'(dac_b_code), 32'hABC);
    chk("R6", 32'(dac_b_pdmode), 1);
    chk("R6", 32'(dac_b_refbuf), 0);
    chk("R9", 32'(dac_a_code), 32'h456);

    // R8: stray clocks with select high, then a clean frame
    cur_req = "R8";
    sdin = 1;
    for (int k = 0; k < 6; k++) begin
      sclk = 0; repeat (HALF) @(negedge clk);
      sclk = 1; repeat (HALF) @(negedge clk);
    end
    pulse_load();
    chk("R8", 32'(dac_a_code), 32'h456);
    send_frame(16'h0777);
    pulse_load();
    chk("R8", 32'(dac_a_code), 32'h777);
    chk("R8", 32'({dac_a_refbuf, dac_a_pdmode}), 0);
    chk("R9", 32'(dac_b_code), 32'hABC);

    // R7: load already low when the frame completes
    cur_req = "R7";
    load_n = 0;
    repeat (4) @(negedge clk);
    send_frame(16'h7F00);
    repeat (6) @(negedge clk);
    chk("R7", 32'(dac_a_code), 32'hF00);
    chk("R7", 32'(dac_a_refbuf), 1);
    chk("R7", 32'(dac_a_pdmode), 3);
    load_n = 1;
    repeat (6) @(negedge clk);

    // R2: another pattern on channel B
    cur_req = "R2";
    send_frame(16'hC001);
    pulse_load();
    chk("R2", 32'(dac_b_code), 32'h001);
    chk("R2", 32'(dac_b_refbuf), 1);
    chk("R2", 32'(dac_b_pdmode), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule